// File: doc/BRIEF.md
# Profile-Switched Oscillator Core with Linear Frequency Ramp

This block is the phase-generation core of a digital synthesizer. A frequency register sets the per-clock step of a 32-bit phase accumulator. The top 14 bits of that accumulator, plus a phase offset, form the phase word that a downstream sine lookup would consume. Eight profiles each hold a frequency tuning word and a phase offset. They are loaded through a small address/data/write-enable port. A 3-bit select input picks the profile in use, and a change of select takes effect without any load strobe.

Each accumulator has its own clear input. While a clear is asserted, the matching accumulator is forced to zero and held there. When sweep mode is off, the frequency register simply tracks the tuning word of the active profile. When sweep mode is on, the frequency register is driven by ramp commands instead. A ramp-up command steers it toward the profile 1 tuning word, and a ramp-down command steers it toward the profile 0 tuning word. The frequency moves by a programmable delta once every (rate + 1) clocks and stops exactly at the target.

Top module: `dds_profile_sweep`

## Requirements
- R1: After synchronous reset, `phase_out` is 0, every profile holds tuning word 0 and offset 0, and the ramp state is idle.
- R2: A cycle with `wr_en` high stores `wr_ftw` and `wr_pow` into the profile selected by `wr_addr` (0..7) at that clock edge.
- R3: The offset and tuning word of the profile named by `prof_sel` are used at the next clock edge after `prof_sel` changes, with no other strobe.
- R4: While `clr_freq` is high, the frequency register is 0 from the next edge on, so the phase accumulator stops advancing and `phase_out` stays constant when the offset does not change.
- R5: While `clr_phase` is high, the phase accumulator is 0 from the next edge on, so `phase_out` equals the active profile offset.
- R6: With `sweep_en` low and no clear, the frequency register loads the active profile tuning word on every edge, and the phase accumulator adds the frequency register on every edge.
- R7: With `sweep_en` high after a `ramp_up` command, the frequency moves toward the profile 1 tuning word by `sweep_delta` once every `sweep_rate`+1 clocks.
- R8: With `sweep_en` high after a `ramp_down` command, the frequency moves toward the profile 0 tuning word in the same way.
- R9: A ramp step that would pass its target lands exactly on the target, and the frequency then stays there.
- R10: Ramp commands are ignored while `sweep_en` is low, and the ramp state returns to idle. `ramp_up` wins when both commands arrive together. Before any command arrives, sweep mode holds the frequency.
- R11: `phase_out` is registered and equals (phase accumulator bits 31:18 + active offset) modulo 2^14, using the values from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Profile write enable |
| wr_addr | input | 3 | Profile index for the write |
| wr_ftw | input | 32 | Tuning word to store |
| wr_pow | input | 14 | Phase offset to store |
| prof_sel | input | 3 | Active profile select |
| clr_freq | input | 1 | Clear and hold frequency register |
| clr_phase | input | 1 | Clear and hold phase accumulator |
| sweep_en | input | 1 | Sweep mode enable |
| ramp_up | input | 1 | Command ramp toward profile 1 |
| ramp_down | input | 1 | Command ramp toward profile 0 |
| sweep_delta | input | 32 | Frequency step per ramp tick |
| sweep_rate | input | 16 | Clocks between ticks, minus one |
| phase_out | output | 14 | Phase word for a lookup |

## Verification
The bound checker watches every cycle for the following:
- the two clear-and-hold effects;
- the frequency register following the active tuning word outside sweep mode;
- ramp steps never exceeding the delta;
- no overshoot past the profile 1 endpoint;
- the output sum;
- the ramp state dropping to idle when sweep mode is off.

Other behaviours can only be shown by the bench scenarios, which compare against a behavioural model on every clock. These are the pacing of ticks by the rate value, arrival at the profile 0 endpoint on ramp-down, priority between simultaneous commands, and the write-then-select ordering of the profile bank.

// File: rtl/dds_pkg.sv
package dds_pkg;
    localparam int FTW_W    = 32;
    localparam int POW_W    = 14;
    localparam int NUM_PROF = 8;
    localparam int PROF_AW  = $clog2(NUM_PROF);

    typedef struct packed {
        logic [FTW_W-1:0] ftw;
        logic [POW_W-1:0] pow;
    } prof_t;

    typedef enum logic [1:0] {
        RAMP_IDLE = 2'd0,
        RAMP_UP   = 2'd1,
        RAMP_DOWN = 2'd2
    } ramp_e;

    // Move cur toward tgt by at most d, landing exactly on tgt when closer.
    function automatic logic [FTW_W-1:0] step_toward(
        input logic [FTW_W-1:0] cur,
        input logic [FTW_W-1:0] tgt,
        input logic [FTW_W-1:0] d
    );
        logic [FTW_W-1:0] gap;
        if (cur < tgt) begin
            gap = tgt - cur;
            return (gap <= d) ? tgt : cur + d;
        end else if (cur > tgt) begin
            gap = cur - tgt;
            return (gap <= d) ? tgt : cur - d;
        end
        return tgt;
    endfunction
endpackage

// File: rtl/dds_profile_bank.sv
module dds_profile_bank
    import dds_pkg::*;
#(
    parameter int N_PROF = NUM_PROF,
    localparam int AW    = $clog2(N_PROF)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  prof_t            wr_data,
    input  logic [AW-1:0]    sel,
    output prof_t            act,
    output logic [FTW_W-1:0] lo_ftw,
    output logic [FTW_W-1:0] hi_ftw
);
    prof_t bank [N_PROF];

    for (genvar g = 0; g < N_PROF; g++) begin : g_prof
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[g] <= '0;
            end else if (wr_en && (wr_addr == AW'(g))) begin
                bank[g] <= wr_data;
            end
        end
    end

    assign act    = bank[sel];
    assign lo_ftw = bank[0].ftw;
    assign hi_ftw = bank[1].ftw;
endmodule

// File: rtl/dds_freq_ramp.sv
module dds_freq_ramp
    import dds_pkg::*;
#(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_freq,
    input  logic              sweep_en,
    input  logic              ramp_up,
    input  logic              ramp_down,
    input  logic [FTW_W-1:0]  act_ftw,
    input  logic [FTW_W-1:0]  lo_ftw,
    input  logic [FTW_W-1:0]  hi_ftw,
    input  logic [FTW_W-1:0]  delta,
    input  logic [RATE_W-1:0] rate,
    output logic [FTW_W-1:0]  freq_word,
    output ramp_e             ramp_state
);
    logic [RATE_W-1:0] tick_cnt;
    logic              tick;
    logic [FTW_W-1:0]  target;

    assign tick   = (tick_cnt == rate);
    assign target = (ramp_state == RAMP_UP) ? hi_ftw : lo_ftw;

    // Direction register: commands only act in sweep mode.
    always_ff @(posedge clk) begin
        if (rst || !sweep_en) begin
            ramp_state <= RAMP_IDLE;
        end else if (ramp_up) begin
            ramp_state <= RAMP_UP;
        end else if (ramp_down) begin
            ramp_state <= RAMP_DOWN;
        end
    end

    // Pacing counter: one tick every rate+1 clocks while ramping.
    always_ff @(posedge clk) begin
        if (rst || clr_freq || !sweep_en || ramp_state == RAMP_IDLE) begin
            tick_cnt <= '0;
        end else if (tick) begin
            tick_cnt <= '0;
        end else begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_freq) begin
            freq_word <= '0;
        end else if (!sweep_en) begin
            freq_word <= act_ftw;
        end else if (ramp_state != RAMP_IDLE && tick) begin
            freq_word <= step_toward(freq_word, target, delta);
        end
    end
endmodule

// File: rtl/dds_phase_gen.sv
module dds_phase_gen
    import dds_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_phase,
    input  logic [FTW_W-1:0] freq_word,
    input  logic [POW_W-1:0] act_pow,
    output logic [FTW_W-1:0] phase_acc,
    output logic [POW_W-1:0] phase_out
);
    always_ff @(posedge clk) begin
        if (rst || clr_phase) begin
            phase_acc <= '0;
        end else begin
            phase_acc <= phase_acc + freq_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_out <= '0;
        end else begin
            phase_out <= phase_acc[FTW_W-1 -: POW_W] + act_pow;
        end
    end
endmodule

// File: rtl/dds_profile_sweep.sv
module dds_profile_sweep
    import dds_pkg::*;
#(
    parameter int RATE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [PROF_AW-1:0]  wr_addr,
    input  logic [FTW_W-1:0]    wr_ftw,
    input  logic [POW_W-1:0]    wr_pow,
    input  logic [PROF_AW-1:0]  prof_sel,
    input  logic                clr_freq,
    input  logic                clr_phase,
    input  logic                sweep_en,
    input  logic                ramp_up,
    input  logic                ramp_down,
    input  logic [FTW_W-1:0]    sweep_delta,
    input  logic [RATE_W-1:0]   sweep_rate,
    output logic [POW_W-1:0]    phase_out
);
    prof_t            wr_data;
    prof_t            act;
    logic [FTW_W-1:0] act_ftw;
    logic [POW_W-1:0] act_pow;
    logic [FTW_W-1:0] lo_ftw;
    logic [FTW_W-1:0] hi_ftw;
    logic [FTW_W-1:0] freq_word;
    logic [FTW_W-1:0] phase_acc;
    ramp_e            ramp_state;

    assign wr_data.ftw = wr_ftw;
    assign wr_data.pow = wr_pow;
    assign act_ftw     = act.ftw;
    assign act_pow     = act.pow;

    dds_profile_bank #(.N_PROF(NUM_PROF)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sel     (prof_sel),
        .act     (act),
        .lo_ftw  (lo_ftw),
        .hi_ftw  (hi_ftw)
    );

    dds_freq_ramp #(.RATE_W(RATE_W)) u_ramp (
        .clk        (clk),
        .rst        (rst),
        .clr_freq   (clr_freq),
        .sweep_en   (sweep_en),
        .ramp_up    (ramp_up),
        .ramp_down  (ramp_down),
        .act_ftw    (act_ftw),
        .lo_ftw     (lo_ftw),
        .hi_ftw     (hi_ftw),
        .delta      (sweep_delta),
        .rate       (sweep_rate),
        .freq_word  (freq_word),
        .ramp_state (ramp_state)
    );

    dds_phase_gen u_phase (
        .clk       (clk),
        .rst       (rst),
        .clr_phase (clr_phase),
        .freq_word (freq_word),
        .act_pow   (act_pow),
        .phase_acc (phase_acc),
        .phase_out (phase_out)
    );
endmodule

// File: rtl/dds_sweep_chk.sv
module dds_sweep_chk
    import dds_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             clr_freq,
    input logic             clr_phase,
    input logic             sweep_en,
    input logic [FTW_W-1:0] sweep_delta,
    input logic [FTW_W-1:0] act_ftw,
    input logic [POW_W-1:0] act_pow,
    input logic [FTW_W-1:0] hi_ftw,
    input logic [FTW_W-1:0] freq_word,
    input logic [FTW_W-1:0] phase_acc,
    input logic [1:0]       ramp_state,
    input logic [POW_W-1:0] phase_out
);
    function automatic logic [FTW_W-1:0] gap(input logic [FTW_W-1:0] a, input logic [FTW_W-1:0] b);
        return (a > b) ? a - b : b - a;
    endfunction

    AST_FREQ_HELD_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr_freq |=> freq_word == '0); // R4

    AST_PHASE_HELD_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr_phase |=> phase_acc == '0); // R5

    AST_FREQ_FOLLOWS_PROFILE: assert property (@(posedge clk) disable iff (rst)
        (!sweep_en && !clr_freq) |=> freq_word == $past(act_ftw)); // R6

    AST_STEP_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        (sweep_en && !clr_freq) |=> gap(freq_word, $past(freq_word)) <= $past(sweep_delta)); // R7

    AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (rst)
        (sweep_en && !clr_freq && ramp_state == RAMP_UP && freq_word <= hi_ftw)
        |=> freq_word <= $past(hi_ftw)); // R9

    AST_IDLE_WITHOUT_SWEEP: assert property (@(posedge clk) disable iff (rst)
        !sweep_en |=> ramp_state == RAMP_IDLE); // R10

    AST_OUTPUT_SUM: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> phase_out == POW_W'($past(phase_acc[FTW_W-1 -: POW_W]) + $past(act_pow))); // R11
endmodule

bind dds_profile_sweep dds_sweep_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .clr_freq    (clr_freq),
    .clr_phase   (clr_phase),
    .sweep_en    (sweep_en),
    .sweep_delta (sweep_delta),
    .act_ftw     (act_ftw),
    .act_pow     (act_pow),
    .hi_ftw      (hi_ftw),
    .freq_word   (freq_word),
    .phase_acc   (phase_acc),
    .ramp_state  (ramp_state),
    .phase_out   (phase_out)
);

// File: tb/test_dds_profile_sweep.sv
module test_dds_profile_sweep;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [31:0] wr_ftw;
    logic [13:0] wr_pow;
    logic [2:0]  prof_sel;
    logic        clr_freq, clr_phase, sweep_en, ramp_up, ramp_down;
    logic [31:0] sweep_delta;
    logic [15:0] sweep_rate;
    logic [13:0] phase_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string cur_req = "R1";

    dds_profile_sweep i_dds_profile_sweep (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    logic [31:0] m_ftw [8];
    logic [13:0] m_pow [8];
    logic [31:0] m_freq, m_phase;
    logic [13:0] m_out;
    int          m_dir;   // 0 idle, 1 up, 2 down
    int          m_cnt;

    function automatic logic [31:0] ref_step(logic [31:0] cur, logic [31:0] tgt, logic [31:0] d);
        if (tgt > cur) return (tgt - cur > d) ? cur + d : tgt;
        if (cur > tgt) return (cur - tgt > d) ? cur - d : tgt;
        return tgt;
    endfunction

    always @(posedge clk) begin
        logic [31:0] n_freq, n_phase;
        logic [13:0] n_out;
        int n_dir, n_cnt;
        cycles++;
        if (rst) begin
            for (int i = 0; i < 8; i++) begin m_ftw[i] = 0; m_pow[i] = 0; end
            m_freq = 0; m_phase = 0; m_out = 0; m_dir = 0; m_cnt = 0;
        end else begin
            n_out   = m_phase[31:18] + m_pow[prof_sel];
            n_phase = clr_phase ? 32'd0 : m_phase + m_freq;
            n_freq  = m_freq;
            n_cnt   = m_cnt;
            if (clr_freq) n_freq = 0;
            else if (!sweep_en) n_freq = m_ftw[prof_sel];
            else if (m_dir != 0 && m_cnt == int'(sweep_rate))
                n_freq = ref_step(m_freq, (m_dir == 1) ? m_ftw[1] : m_ftw[0], sweep_delta);
            if (clr_freq || !sweep_en || m_dir == 0) n_cnt = 0;
            else n_cnt = (m_cnt == int'(sweep_rate)) ? 0 : m_cnt + 1;
            n_dir = m_dir;
            if (!sweep_en) n_dir = 0;
            else if (ramp_up) n_dir = 1;
            else if (ramp_down) n_dir = 2;
            if (wr_en) begin m_ftw[wr_addr] = wr_ftw; m_pow[wr_addr] = wr_pow; end
            m_out = n_out; m_phase = n_phase; m_freq = n_freq; m_dir = n_dir; m_cnt = n_cnt;
        end
    end

    task automatic check(string req, logic [13:0] act, logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: phase_out actual %h expected %h (cycle %0d)", req, act, exp, cycles);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) check(cur_req, phase_out, m_out);
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] f, logic [13:0] p);
        wr_en = 1; wr_addr = a; wr_ftw = f; wr_pow = p;
        cyc(1);
        wr_en = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [13:0] held;
        rst = 1; wr_en = 0; wr_addr = 0; wr_ftw = 0; wr_pow = 0; prof_sel = 0;
        clr_freq = 0; clr_phase = 0; sweep_en = 0; ramp_up = 0; ramp_down = 0;
        sweep_delta = 0; sweep_rate = 0;
        cyc(3);
        rst = 0;
        cyc(1);
        check("R1", phase_out, 14'h0);

        cur_req = "R2";
        wr(3'd0, 32'h0010_0000, 14'h0100);
        wr(3'd1, 32'h0080_0000, 14'h0200);
        wr(3'd2, 32'h0004_0000, 14'h3FF0);
        wr(3'd5, 32'h1234_5678, 14'h0ABC);
        wr(3'd7, 32'hFFFF_0000, 14'h1555);

        cur_req = "R6";
        prof_sel = 2;
        cyc(20);
        cur_req = "R11";
        prof_sel = 7;
        cyc(12);
        cur_req = "R3";
        for (int i = 0; i < 16; i++) begin
            prof_sel = 3'(i * 5);
            cyc(1);
        end

        cur_req = "R5";
        prof_sel = 2;
        clr_phase = 1;
        cyc(3);
        check("R5", phase_out, 14'h3FF0);
        clr_phase = 0;
        cyc(5);

        cur_req = "R4";
        prof_sel = 5;
        clr_freq = 1;
        cyc(4);
        held = phase_out;
        cyc(3);
        check("R4", phase_out, held);
        clr_freq = 0;
        cyc(4);

        cur_req = "R10";
        prof_sel = 0;
        ramp_up = 1;
        cyc(2);
        ramp_up = 0;
        cyc(3);
        sweep_en = 1;
        cyc(6);

        cur_req = "R7";
        sweep_delta = 32'h0003_0000;
        sweep_rate = 16'd3;
        ramp_up = 1; cyc(1); ramp_up = 0;
        cyc(200);
        cur_req = "R8";
        ramp_down = 1; cyc(1); ramp_down = 0;
        cyc(220);

        cur_req = "R9";
        sweep_delta = 32'h0100_0000;
        sweep_rate = 16'd0;
        ramp_up = 1; cyc(1); ramp_up = 0;
        cyc(10);
        ramp_down = 1; cyc(1); ramp_down = 0;
        cyc(10);

        cur_req = "R10";
        sweep_delta = 32'h0001_0000;
        sweep_rate = 16'd1;
        ramp_up = 1; ramp_down = 1; cyc(1);
        ramp_up = 0; ramp_down = 0;
        cyc(30);
        sweep_en = 0;
        ramp_down = 1; cyc(2); ramp_down = 0;
        cyc(5);

        cur_req = "R2";
        wr(3'd3, 32'h0002_0000, 14'h0333);
        prof_sel = 3;
        cyc(10);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule